// File: doc/BRIEF.md
# Tap-Select LFSR Engine

This block is a programmable linear-feedback shift engine for CRC computation, scrambling and pseudo-random sequences. A 40-bit residue register advances one position per clock while a run is active. Its new bit 0, the decision whether to fold in the 40-bit polynomial register, and the serial output bit are each formed by XOR gating over residue bits. Those bits are picked by five independent tap selectors, and the gating can also include the serial input bit.

Serial input comes from a 16-bit data-in word, taken LSB-first or MSB-first. The serial output is collected into a 16-bit data-out word. A 32-bit compare word is matched against a window of the residue. That window follows the residue's byte mapping.

Software reaches every register over a byte-wide bus. A run is started by a command write that holds the bit count. The engine stalls when the data-in word has been used up, and resumes once the word is reloaded.

Top module: `lfsr_engine`

## Requirements
- R1: On each shift the residue moves bits 0..38 into positions 1..39. Bit 0 receives the feedback bit. The feedback bit is the XOR of the feedback-enabled taps, and of the serial input bit if that is enabled. Feedback enable byte (address 23): bits 0..3 enable taps 0..3, and bit 4 enables the serial input. When no shift and no residue write occur, the residue holds.
- R2: If the polynomial gating bit is 1 on a shift, the shifted residue is XORed with polynomial bits 39..1, and bit 0 is left untouched. The gating bit is formed like the feedback bit from the enable byte at address 24, which has the same layout. The polynomial occupies bytes 5..9, with bit 0 at the low end of byte 5.
- R3: Five tap selectors (addresses 18..22, values 0..39) each pick one residue bit. The serial output bit is the XOR of the output-enabled taps, and of the serial input bit if that is enabled. Output enable byte (address 25): bits 0..4 enable taps 0..4, and bit 5 enables the serial input.
- R4: The data-in word sits at addresses 10 (low byte) and 11 (high byte). The k-th shift after a reload uses data-in bit k when configuration bit 1 (address 26) is 0. It uses bit 15-k when that bit is 1.
- R5: On each shift the output bit enters bit 15 of the data-out word and the other bits move down one place. After 16 shifts the first bit is in bit 0. The data-out word is read at addresses 12 (low) and 13 (high).
- R6: Writing address 27 with value n-1 in bits 3..0 starts a run of exactly n shifts, with n from 1 to 16. The busy pin is 1 during the run. When the run ends, busy is 0 and done is 1. The next command clears done.
- R7: After 16 shifts since the last write of the data-in high byte, the engine stalls with busy held at 1 and the residue unchanged. Writing the high byte resumes the run. Reset leaves the data-in word marked as used up.
- R8: The residue is read and written as bytes 0..4 (addresses 0..4) through a view that configuration bit 0 selects. With the bit set, residue bit i is view bit i. With the bit clear, residue bit 39-i is view bit i, so residue bit 0 appears as bit 7 of byte 4.
- R9: The match pin is 1 exactly when view bits 31..0 equal the compare word (addresses 14..17, low byte first). View bits 39..32 are ignored.
- R10: After reset every register is 0, busy and done are 0, and match is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Register byte address |
| busWrData | input | 8 | Write data |
| busWe | input | 1 | Write strobe |
| busRdData | output | 8 | Combinational read data for busAddr |
| busy | output | 1 | Run in progress, including stalls |
| done | output | 1 | Last run completed |
| match | output | 1 | Compare window equals compare word |

## Verification
The embedded assertions cover several properties on every clock:
- the residue holds when there is neither a shift nor a write;
- the residue moves up by one bit, with or without the polynomial fold;
- the data-out word shifts down;
- done excludes busy;
- a stall freezes the remaining bit count;
- the data-in pointer stays in range.

Only the bench scenarios can show that the tap selection, the gating enables and the serial input order give the right residue and data-out values after a full run. The same applies to the shift count being exact, a stall releasing on reload, the two byte mappings, and the compare window ignoring the top byte.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  localparam int RES_W     = 40;
  localparam int CMP_W     = 32;
  localparam int DIN_W     = 16;
  localparam int BYTE_W    = 8;
  localparam int N_FB      = 4;
  localparam int N_TAP     = N_FB + 1;
  localparam int ADDR_W    = 5;
  localparam int RES_BYTES = RES_W / BYTE_W;
  localparam int CMP_BYTES = CMP_W / BYTE_W;
  localparam int DIN_BYTES = DIN_W / BYTE_W;
  localparam int SEL_W     = $clog2(RES_W);
  localparam int IDX_W     = $clog2(DIN_W);
  localparam int PTR_W     = IDX_W + 1;
  localparam int CNT_W     = IDX_W + 1;

  localparam int A_RES  = 0;
  localparam int A_POLY = A_RES + RES_BYTES;
  localparam int A_DIN  = A_POLY + RES_BYTES;
  localparam int A_DOUT = A_DIN + DIN_BYTES;
  localparam int A_CMP  = A_DOUT + DIN_BYTES;
  localparam int A_TAP  = A_CMP + CMP_BYTES;
  localparam int A_FBEN = A_TAP + N_TAP;
  localparam int A_PEN  = A_FBEN + 1;
  localparam int A_OEN  = A_PEN + 1;
  localparam int A_CFG  = A_OEN + 1;
  localparam int A_CMD  = A_CFG + 1;

  typedef struct packed {
    logic             shiftEn;
    logic [IDX_W-1:0] inIdx;
  } strobe_t;

  function automatic logic [RES_W-1:0] bitRev(input logic [RES_W-1:0] v);
    logic [RES_W-1:0] r;
    for (int i = 0; i < RES_W; i++) r[i] = v[RES_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/lfsr_tap_mux.sv
module lfsr_tap_mux #(
  parameter int W = 40,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  input  logic [SW-1:0] sel,
  output logic          tapBit
);
  always_comb begin
    tapBit = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (sel == SW'(i)) tapBit = vec[i];
    end
  end
endmodule

// File: rtl/lfsr_ctrl.sv
module lfsr_ctrl
  import lfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [IDX_W-1:0]  cmdCount,
  input  logic              busWe,
  output strobe_t           stb,
  output logic              busy,
  output logic              done
);
  logic [PTR_W-1:0] inPtr;
  logic [CNT_W-1:0] bitsLeft;
  logic inEmpty, shiftGo, cmdWr, reloadWr;

  assign inEmpty  = (inPtr == PTR_W'(DIN_W));
  assign shiftGo  = busy && !inEmpty;
  assign cmdWr    = busWe && (busAddr == ADDR_W'(A_CMD));
  assign reloadWr = busWe && (busAddr == ADDR_W'(A_DIN + DIN_BYTES - 1));

  assign stb.shiftEn = shiftGo;
  assign stb.inIdx   = inPtr[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      bitsLeft <= '0;
    end else if (cmdWr) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      bitsLeft <= {1'b0, cmdCount} + CNT_W'(1);
    end else if (shiftGo) begin
      bitsLeft <= bitsLeft - CNT_W'(1);
      if (bitsLeft == CNT_W'(1)) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         inPtr <= PTR_W'(DIN_W);
    else if (reloadWr) inPtr <= '0;
    else if (shiftGo)  inPtr <= inPtr + PTR_W'(1);
  end

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN) done |-> !busy); // R6
  AST_FINISH_SETS_DONE: assert property (@(posedge clk) disable iff (!rstN) $fell(busy) |-> done); // R6
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rstN) inPtr <= PTR_W'(DIN_W)); // R7
  AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rstN) busy && inEmpty && !cmdWr |=> $stable(bitsLeft)); // R7
endmodule

// File: rtl/lfsr_datapath.sv
module lfsr_datapath
  import lfsr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BYTE_W-1:0] busWrData,
  input  logic              busWe,
  input  strobe_t           stb,
  input  logic              busy,
  input  logic              done,
  output logic [BYTE_W-1:0] busRdData,
  output logic              match
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(DIN_W - 1);

  logic [RES_W-1:0] res, poly, resView, viewWr, resFromBus, resShift;
  logic [DIN_W-1:0] din, dout;
  logic [CMP_W-1:0] cmp;
  logic [SEL_W-1:0] tapSel [N_TAP];
  logic [N_FB:0]    fbEn, polyEn;
  logic [N_TAP:0]   outEn;
  logic             mapBit, msbFirst;
  logic [N_TAP-1:0] taps;
  logic dinBit, fbBit, polyBit, outBit, resWrHit;

  // tap multiplexers: taps 0..3 feed all gates, tap 4 only the output gate
  for (genvar g = 0; g < N_TAP; g++) begin : gTap
    lfsr_tap_mux #(.W(RES_W), .SW(SEL_W)) uMux (
      .vec(res), .sel(tapSel[g]), .tapBit(taps[g]));
  end

  assign dinBit  = msbFirst ? din[IDX_MAX - stb.inIdx] : din[stb.inIdx];
  assign fbBit   = (^(taps[N_FB-1:0] & fbEn[N_FB-1:0]))   ^ (fbEn[N_FB] & dinBit);
  assign polyBit = (^(taps[N_FB-1:0] & polyEn[N_FB-1:0])) ^ (polyEn[N_FB] & dinBit);
  assign outBit  = (^(taps & outEn[N_TAP-1:0]))           ^ (outEn[N_TAP] & dinBit);

  assign resShift = {res[RES_W-2:0], fbBit} ^ (polyBit ? {poly[RES_W-1:1], 1'b0} : '0);
  assign resView  = mapBit ? res : bitRev(res);
  assign match    = (resView[CMP_W-1:0] == cmp);

  always_comb begin
    viewWr   = resView;
    resWrHit = 1'b0;
    for (int k = 0; k < RES_BYTES; k++) begin
      if (busWe && busAddr == ADDR_W'(A_RES + k)) begin
        viewWr[k*BYTE_W +: BYTE_W] = busWrData;
        resWrHit = 1'b1;
      end
    end
  end
  assign resFromBus = mapBit ? viewWr : bitRev(viewWr);

  always_ff @(posedge clk) begin
    if (!rstN)            res <= '0;
    else if (resWrHit)    res <= resFromBus;
    else if (stb.shiftEn) res <= resShift;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dout <= '0;
    else if (stb.shiftEn) dout <= {outBit, dout[DIN_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      poly     <= '0;
      din      <= '0;
      cmp      <= '0;
      fbEn     <= '0;
      polyEn   <= '0;
      outEn    <= '0;
      mapBit   <= 1'b0;
      msbFirst <= 1'b0;
      for (int k = 0; k < N_TAP; k++) tapSel[k] <= '0;
    end else if (busWe) begin
      for (int k = 0; k < RES_BYTES; k++)
        if (busAddr == ADDR_W'(A_POLY + k)) poly[k*BYTE_W +: BYTE_W] <= busWrData;
      for (int k = 0; k < DIN_BYTES; k++)
        if (busAddr == ADDR_W'(A_DIN + k)) din[k*BYTE_W +: BYTE_W] <= busWrData;
      for (int k = 0; k < CMP_BYTES; k++)
        if (busAddr == ADDR_W'(A_CMP + k)) cmp[k*BYTE_W +: BYTE_W] <= busWrData;
      for (int k = 0; k < N_TAP; k++)
        if (busAddr == ADDR_W'(A_TAP + k)) tapSel[k] <= busWrData[SEL_W-1:0];
      if (busAddr == ADDR_W'(A_FBEN)) fbEn   <= busWrData[N_FB:0];
      if (busAddr == ADDR_W'(A_PEN))  polyEn <= busWrData[N_FB:0];
      if (busAddr == ADDR_W'(A_OEN))  outEn  <= busWrData[N_TAP:0];
      if (busAddr == ADDR_W'(A_CFG)) begin
        mapBit   <= busWrData[0];
        msbFirst <= busWrData[1];
      end
    end
  end

  always_comb begin
    busRdData = '0;
    for (int k = 0; k < RES_BYTES; k++) begin
      if (busAddr == ADDR_W'(A_RES + k))  busRdData = resView[k*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_W'(A_POLY + k)) busRdData = poly[k*BYTE_W +: BYTE_W];
    end
    for (int k = 0; k < DIN_BYTES; k++) begin
      if (busAddr == ADDR_W'(A_DIN + k))  busRdData = din[k*BYTE_W +: BYTE_W];
      if (busAddr == ADDR_W'(A_DOUT + k)) busRdData = dout[k*BYTE_W +: BYTE_W];
    end
    for (int k = 0; k < CMP_BYTES; k++)
      if (busAddr == ADDR_W'(A_CMP + k)) busRdData = cmp[k*BYTE_W +: BYTE_W];
    for (int k = 0; k < N_TAP; k++)
      if (busAddr == ADDR_W'(A_TAP + k)) busRdData = BYTE_W'(tapSel[k]);
    if (busAddr == ADDR_W'(A_FBEN)) busRdData = BYTE_W'(fbEn);
    if (busAddr == ADDR_W'(A_PEN))  busRdData = BYTE_W'(polyEn);
    if (busAddr == ADDR_W'(A_OEN))  busRdData = BYTE_W'(outEn);
    if (busAddr == ADDR_W'(A_CFG))  busRdData = BYTE_W'({msbFirst, mapBit});
    if (busAddr == ADDR_W'(A_CMD))  busRdData = BYTE_W'({match, done, busy});
  end

  AST_IDLE_HOLDS_RES: assert property (@(posedge clk) disable iff (!rstN) !stb.shiftEn && !resWrHit |=> $stable(res)); // R1
  AST_BITS_MOVE_UP: assert property (@(posedge clk) disable iff (!rstN) stb.shiftEn && !resWrHit && !polyBit |=> res[RES_W-1:1] == $past(res[RES_W-2:0])); // R1
  AST_POLY_FOLDED: assert property (@(posedge clk) disable iff (!rstN) stb.shiftEn && !resWrHit && polyBit |=> res[RES_W-1:1] == ($past(res[RES_W-2:0]) ^ $past(poly[RES_W-1:1]))); // R2
  AST_OUT_SHIFTS_DOWN: assert property (@(posedge clk) disable iff (!rstN) stb.shiftEn |=> dout[DIN_W-2:0] == $past(dout[DIN_W-1:1])); // R5
endmodule

// File: rtl/lfsr_engine.sv
module lfsr_engine
  import lfsr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [4:0]  busAddr,
  input  logic [7:0]  busWrData,
  input  logic        busWe,
  output logic [7:0]  busRdData,
  output logic        busy,
  output logic        done,
  output logic        match
);
  strobe_t stb;

  lfsr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr),
    .cmdCount(busWrData[IDX_W-1:0]), .busWe(busWe),
    .stb(stb), .busy(busy), .done(done));

  lfsr_datapath uDp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .stb(stb), .busy(busy), .done(done),
    .busRdData(busRdData), .match(match));
endmodule

// File: tb/tb_lfsr_engine.sv
module tb_lfsr_engine;
  logic clk = 1'b0, rstN = 1'b0;
  logic [4:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic busWe = 1'b0;
  logic [7:0] busRdData;
  logic busy, done, match;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  lfsr_engine dut (.clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWe(busWe), .busRdData(busRdData), .busy(busy), .done(done), .match(match));

  typedef struct packed {
    logic [5:0] t0, t1, t2, t3, t4;
    logic [4:0] fe, pe;
    logic [5:0] oe;
    logic       msb;
    logic [15:0] d;
    logic [39:0] r, p;
    logic [3:0] n;
  } vec_t;

  localparam vec_t VEC [4] = '{
    '{6'd39, 6'd0, 6'd0, 6'd0, 6'd0, 5'b10000, 5'b00000, 6'b000001, 1'b0,
      16'hA5C3, 40'h00_0000_0000, 40'h00_0000_0000, 4'd15},
    '{6'd39, 6'd1, 6'd2, 6'd3, 6'd4, 5'b10001, 5'b10001, 6'b100001, 1'b1,
      16'h1234, 40'hFF_FFFF_FFFF, 40'h80_0001_0211, 4'd15},
    '{6'd39, 6'd20, 6'd0, 6'd0, 6'd0, 5'b00011, 5'b00000, 6'b000011, 1'b0,
      16'h0000, 40'h00_0000_0001, 40'h00_0000_0000, 4'd11},
    '{6'd7, 6'd9, 6'd3, 6'd30, 6'd5, 5'b01011, 5'b00100, 6'b110000, 1'b1,
      16'hF00F, 40'h12_3456_789A, 40'h55_AAAA_5555, 4'd7}
  };

  // independent reference state
  logic [5:0]  mTap [5];
  logic [4:0]  mFe, mPe;
  logic [5:0]  mOe;
  logic        mMsb;
  logic [15:0] mD, mOut;
  logic [39:0] mRes, mPoly;
  int          mPtr;

  task automatic modelShift(input int n);
    for (int s = 0; s < n; s++) begin
      logic inb, fb, pb, ob;
      logic [4:0] t;
      inb = mMsb ? mD[15 - mPtr] : mD[mPtr];
      for (int j = 0; j < 5; j++) t[j] = mRes[mTap[j]];
      fb = (^(t[3:0] & mFe[3:0])) ^ (mFe[4] & inb);
      pb = (^(t[3:0] & mPe[3:0])) ^ (mPe[4] & inb);
      ob = (^(t & mOe[4:0])) ^ (mOe[5] & inb);
      mRes = {mRes[38:0], fb};
      if (pb) mRes = mRes ^ {mPoly[39:1], 1'b0};
      mOut = {ob, mOut[15:1]};
      mPtr++;
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    busAddr = 5'(a); busWrData = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    busAddr = 5'(a);
    #1 d = busRdData;
  endtask

  task automatic wrRes(input logic [39:0] v);
    for (int k = 0; k < 5; k++) wr(k, v[k*8 +: 8]);
  endtask

  task automatic rdRes(output logic [39:0] v);
    logic [7:0] b;
    for (int k = 0; k < 5; k++) begin rd(k, b); v[k*8 +: 8] = b; end
  endtask

  task automatic rdOut(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(12, lo); rd(13, hi);
    v = {hi, lo};
  endtask

  task automatic waitDone();
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [39:0] rv;
    logic [15:0] ov;
    logic [7:0]  b;
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R10 reset state
    check("R10 busy", 64'(busy), 64'd0);
    check("R10 done", 64'(done), 64'd0);
    check("R10 match", 64'(match), 64'd1);
    rdRes(rv); check("R10 residue", 64'(rv), 64'd0);
    rdOut(ov); check("R10 dataout", 64'(ov), 64'd0);

    // R7 reset leaves data-in used up: run stalls until reload
    mRes = '0; mPoly = '0; mOut = '0; mFe = '0; mPe = '0; mOe = '0; mMsb = 0; mD = '0;
    for (int j = 0; j < 5; j++) mTap[j] = '0;
    wr(27, 8'h00);
    idle(6);
    check("R7 stall after reset busy", 64'(busy), 64'd1);
    wr(11, 8'h00);
    mPtr = 0; modelShift(1);
    waitDone();
    check("R7 resume after reload done", 64'(done), 64'd1);

    // vector table
    for (int v = 0; v < 4; v++) begin
      vec_t c;
      c = VEC[v];
      wr(18, 8'(c.t0)); wr(19, 8'(c.t1)); wr(20, 8'(c.t2)); wr(21, 8'(c.t3)); wr(22, 8'(c.t4));
      wr(23, 8'(c.fe)); wr(24, 8'(c.pe)); wr(25, 8'(c.oe));
      wr(26, {6'd0, c.msb, 1'b1});
      wrRes(c.r);
      for (int k = 0; k < 5; k++) wr(5 + k, c.p[k*8 +: 8]);
      wr(10, c.d[7:0]); wr(11, c.d[15:8]);
      mTap[0] = c.t0; mTap[1] = c.t1; mTap[2] = c.t2; mTap[3] = c.t3; mTap[4] = c.t4;
      mFe = c.fe; mPe = c.pe; mOe = c.oe; mMsb = c.msb; mD = c.d;
      mRes = c.r; mPoly = c.p; mPtr = 0;
      modelShift(int'(c.n) + 1);
      wr(27, {4'd0, c.n});
      check($sformatf("R6 busy during run v%0d", v), 64'(busy), 64'd1);
      waitDone();
      check($sformatf("R6 done after run v%0d", v), 64'({busy, done}), 64'b01);
      rdRes(rv);
      check($sformatf("R1 R2 R4 residue v%0d", v), 64'(rv), 64'(mRes));
      rdOut(ov);
      check($sformatf("R3 R5 dataout v%0d", v), 64'(ov), 64'(mOut));
    end

    // R7 exhaustion mid-run and release on high-byte reload
    wr(23, 8'h10); wr(24, 8'h00); wr(25, 8'h00); wr(26, 8'h01);
    wr(10, 8'hFF); wr(11, 8'hFF);
    mFe = 5'b10000; mPe = '0; mOe = '0; mMsb = 0; mD = 16'hFFFF; mPtr = 0;
    modelShift(16);
    wr(27, 8'h0F);
    waitDone();
    rdRes(rv);
    check("R7 full word residue", 64'(rv), 64'(mRes));
    wr(27, 8'h03);
    idle(8);
    check("R7 stalled busy", 64'({busy, done}), 64'b10);
    rdRes(rv);
    check("R7 stalled residue unchanged", 64'(rv), 64'(mRes));
    wr(11, 8'hFF);
    mPtr = 0; modelShift(4);
    waitDone();
    rdRes(rv);
    check("R7 resumed residue", 64'(rv), 64'(mRes));

    // R8 byte mapping
    wr(26, 8'h01);
    wrRes(40'h00_0000_0001);
    wr(26, 8'h00);
    rd(4, b); check("R8 bit0 seen at byte4 bit7", 64'(b), 64'h80);
    rd(0, b); check("R8 byte0 reversed view", 64'(b), 64'h00);
    wrRes(40'h00_0000_0001);
    wr(26, 8'h01);
    rd(4, b); check("R8 reversed write lands at bit39", 64'(b), 64'h80);

    // R9 compare window
    wrRes(40'hAB_1234_5678);
    wr(14, 8'h78); wr(15, 8'h56); wr(16, 8'h34); wr(17, 8'h12);
    @(negedge clk);
    check("R9 match direct map", 64'(match), 64'd1);
    wr(4, 8'hCD);
    @(negedge clk);
    check("R9 top byte ignored", 64'(match), 64'd1);
    wr(0, 8'h79);
    @(negedge clk);
    check("R9 low bit differs", 64'(match), 64'd0);
    wr(26, 8'h00);
    wrRes(40'h5A_1234_5678);
    @(negedge clk);
    check("R9 match reversed map", 64'(match), 64'd1);
    rd(27, b);
    check("R9 status byte match bit", 64'(b[2]), 64'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule